// File: doc/BRIEF.md
# Latched Graphics ROM Bank Translator

This block turns each fetch address in the 8 KB video pattern space into a 1 KB graphics-ROM page number. Eight 16-bit bank registers, each loaded one byte at a time, supply the bank numbers. A mode byte sets the banking granularity to 8, 4, 2 or 1 KB. An outer-control byte either confines every bank to one outer block of the ROM or lets the full 16-bit register value through.

A strap input turns on a snooping mode that applies in 4 KB granularity. In this mode each 4 KB half of the pattern space has its own one-bit latch. The latch moves to a different bank register when the video side fetches one of two marker tile rows in that half. The page output is combinational from the current fetch address and the registered state. Writes and latch changes take effect from the cycle after the clock edge that captures them.

Top module: `gfx_bank_xlate`

## Requirements
- R1: The write port selects a target with wr_kind: 0 is a bank low byte, 1 is a bank high byte, 2 is the mode byte and 3 is the outer-control byte. wr_idx picks the bank for kinds 0 and 1. Bank n reads as {high, low}, and writing one byte of a bank leaves its other byte and every other bank unchanged.
- R2: With mode bits [4:3] = 00 (8 KB), bank 0 is used and page_o = {bank, fetch_addr[12:10]}.
- R3: With mode bits [4:3] = 01 (4 KB) and the strap low, fetch_addr[12] = 0 uses bank 0 and fetch_addr[12] = 1 uses bank 4, and page_o = {bank, fetch_addr[11:10]}.
- R4: With mode bits [4:3] = 10 (2 KB), bank {fetch_addr[12:11], 0} is used and page_o = {bank, fetch_addr[10]}.
- R5: With mode bits [4:3] = 11 (1 KB), bank fetch_addr[12:10] is used and page_o is that bank.
- R6: With outer-control bit 5 clear, let s be 5, 6, 7 or 8 for 8, 4, 2 or 1 KB. The effective bank is (register mod 2^s) + {outer[4:3], outer[0]} * 2^s, so page_o never exceeds 11 bits.
- R7: With outer-control bit 5 set, the effective bank is the full 16-bit register value.
- R8: In 4 KB mode with the strap high, a valid fetch has fetch_addr[13] = 0 and fetch_addr[11:8] = 0xF. If its fetch_addr[7:4] is 0xD, the half chosen by fetch_addr[12] switches to bank 0 (lower) or bank 4 (upper). If it is 0xE, that half switches to bank 2 or bank 6. The page for the triggering fetch uses the old choice, and the new choice applies from the next cycle.
- R9: While the strap is low, 4 KB mode always uses banks 0 and 4 and both latches are cleared. Marker fetches with fetch_valid low, or with fetch_addr[13] = 1, leave the latches unchanged.
- R10: After reset every bank byte is 0xFF, the mode and outer bytes are 0 and both latches select banks 0/4, so page_o = 0xF8 + fetch_addr[12:10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 low byte, 1 high byte, 2 mode, 3 outer control |
| wr_idx | input | 3 | Bank index for byte writes |
| wr_data | input | 8 | Write data |
| latch_en | input | 1 | Strap enabling fetch-snooping latches |
| fetch_valid | input | 1 | Video fetch present this cycle |
| fetch_addr | input | 14 | Video fetch address |
| page_o | output | 19 | 1 KB graphics-ROM page for the current fetch |

## Verification
page_o is due in the same cycle as fetch_addr, so the bench drives each address on a falling edge and compares 1 ns later. A register write or a latch trigger is captured on the next rising edge. It is therefore checked only from the following falling edge. At a trigger, the bench compares the triggering fetch itself against the old selection before that edge. The bench sweeps all four granularities, all eight slots and several outer-control values. It computes each expected page arithmetically from shadow copies of the written bytes.

// File: rtl/gfx_bank_pkg.sv
package gfx_bank_pkg;

    typedef enum logic [1:0] {
        WK_LO    = 2'd0,
        WK_HI    = 2'd1,
        WK_MODE  = 2'd2,
        WK_OUTER = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        G_8K = 2'd0,
        G_4K = 2'd1,
        G_2K = 2'd2,
        G_1K = 2'd3
    } gran_e;

    // smallest inner bank width (8 KB granularity)
    localparam int INNER_MIN_W = 5;
    // bit positions inside the control bytes
    localparam int MODE_GRAN_LSB = 3;
    localparam int OUTER_BYPASS  = 5;

endpackage

// File: rtl/gfx_bank_regfile.sv
module gfx_bank_regfile
    import gfx_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int BANK_W   = 2 * BYTE_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [1:0]                           wr_kind,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic [BYTE_W-1:0]                    wr_data,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]     bank_o,
    output logic [BYTE_W-1:0]                    mode_o,
    output logic [BYTE_W-1:0]                    outer_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BYTE_W-1:0] lo;
        logic [NUM_BANKS-1:0][BYTE_W-1:0] hi;
        logic [BYTE_W-1:0]                mode;
        logic [BYTE_W-1:0]                outer;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_kind)
                WK_LO:    st_d.lo[wr_idx] = wr_data;
                WK_HI:    st_d.hi[wr_idx] = wr_data;
                WK_MODE:  st_d.mode       = wr_data;
                default:  st_d.outer      = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lo    <= '1;
            st_q.hi    <= '1;
            st_q.mode  <= '0;
            st_q.outer <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_o[b] = {st_q.hi[b], st_q.lo[b]};
    end
    assign mode_o  = st_q.mode;
    assign outer_o = st_q.outer;

    // R1: a low-byte write lands and leaves the high byte of that bank alone
    a_r1_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_LO) |=>
            (bank_o[$past(wr_idx)][BYTE_W-1:0] == $past(wr_data)) &&
            (bank_o[$past(wr_idx)][BANK_W-1:BYTE_W] == $past(bank_o[wr_idx][BANK_W-1:BYTE_W])));

    // R1: a high-byte write leaves the low byte alone
    a_r1_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_HI) |=>
            (bank_o[$past(wr_idx)][BANK_W-1:BYTE_W] == $past(wr_data)) &&
            (bank_o[$past(wr_idx)][BYTE_W-1:0] == $past(bank_o[wr_idx][BYTE_W-1:0])));

    // R1: without a write the whole bank file holds
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_o) && $stable(mode_o) && $stable(outer_o));

endmodule

// File: rtl/gfx_fetch_latch.sv
module gfx_fetch_latch #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        sel_o
);

    localparam logic [3:0] ROW_TAG  = 4'hF;
    localparam logic [3:0] COL_BASE = 4'hD;
    localparam logic [3:0] COL_ALT  = 4'hE;

    typedef struct packed {
        logic [1:0] sel;
    } lat_t;

    lat_t st_d, st_q;
    logic marker;
    logic half;

    assign marker = fetch_valid && !fetch_addr[13] && (fetch_addr[11:8] == ROW_TAG);
    assign half   = fetch_addr[12];

    always_comb begin
        st_d = st_q;
        if (!latch_en) begin
            st_d.sel = '0;
        end else if (marker) begin
            if (fetch_addr[7:4] == COL_BASE)
                st_d.sel[half] = 1'b0;
            else if (fetch_addr[7:4] == COL_ALT)
                st_d.sel[half] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;

    // R9: strap low clears both latches on the next edge
    a_r9_strap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (sel_o == 2'b00));

    // R9: no valid fetch, no change
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !fetch_valid) |=> $stable(sel_o));

    // R8: a trigger only touches the half it addresses
    a_r8_other_half: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && fetch_valid) |=> (sel_o[!$past(fetch_addr[12])] == $past(sel_o[!fetch_addr[12]])));

endmodule

// File: rtl/gfx_page_compose.sv
module gfx_page_compose
    import gfx_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 14,
    localparam int BANK_W   = 2 * BYTE_W,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int PAGE_W   = BANK_W + 3,
    localparam int LIMIT_W  = INNER_MIN_W + 3 + 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_i,
    input  logic [BYTE_W-1:0]                mode_i,
    input  logic [BYTE_W-1:0]                outer_i,
    input  logic [1:0]                       sel_i,
    input  logic                             latch_en,
    input  logic [ADDR_W-1:0]                fetch_addr,
    output logic [PAGE_W-1:0]                page_o
);

    logic [1:0]        gran;
    logic [2:0]        slot;
    logic              half_sel;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] raw;
    logic [3:0]        shamt;
    logic [BANK_W-1:0] inner_mask;
    logic [BANK_W-1:0] outer_blk;
    logic [BANK_W-1:0] bank_eff;
    logic [1:0]        low_n;
    logic [2:0]        slot_mask;

    assign gran     = mode_i[MODE_GRAN_LSB +: 2];
    assign slot     = fetch_addr[12:10];
    assign half_sel = latch_en & sel_i[fetch_addr[12]];

    always_comb begin
        case (gran)
            G_8K:    idx = '0;
            G_4K:    idx = IDX_W'({fetch_addr[12], half_sel, 1'b0});
            G_2K:    idx = IDX_W'({fetch_addr[12:11], 1'b0});
            default: idx = IDX_W'(slot);
        endcase
    end

    assign raw        = bank_i[idx];
    assign shamt      = 4'(INNER_MIN_W) + {2'b00, gran};
    assign inner_mask = (BANK_W'(1) << shamt) - BANK_W'(1);
    assign outer_blk  = BANK_W'({outer_i[4:3], outer_i[0]}) << shamt;

    always_comb begin
        if (outer_i[OUTER_BYPASS]) bank_eff = raw;
        else                       bank_eff = (raw & inner_mask) | outer_blk;
    end

    assign low_n     = 2'd3 - gran;
    assign slot_mask = (3'd1 << low_n) - 3'd1;
    assign page_o    = ({3'b000, bank_eff} << low_n) | PAGE_W'(slot & slot_mask);

    // R6: outer limit keeps every page inside 11 bits
    a_r6_outer_range: assert property (@(posedge clk) disable iff (!rst_n)
        !outer_i[OUTER_BYPASS] |-> (page_o[PAGE_W-1:LIMIT_W] == '0));

    // R2: 8 KB granularity passes the slot through as the low page bits
    a_r2_slot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (gran == G_8K) |-> (page_o[2:0] == fetch_addr[12:10]));

    // R5: 1 KB granularity with bypass returns a bank register verbatim
    a_r5_verbatim: assert property (@(posedge clk) disable iff (!rst_n)
        ((gran == G_1K) && outer_i[OUTER_BYPASS]) |-> (page_o == PAGE_W'(bank_i[fetch_addr[12:10]])));

endmodule

// File: rtl/gfx_bank_xlate.sv
module gfx_bank_xlate
    import gfx_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 14,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int BANK_W   = 2 * BYTE_W,
    localparam int PAGE_W   = BANK_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              latch_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [PAGE_W-1:0] page_o
);

    logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
    logic [BYTE_W-1:0]                mode;
    logic [BYTE_W-1:0]                outer;
    logic [1:0]                       sel;

    gfx_bank_regfile #(.NUM_BANKS(NUM_BANKS), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .bank_o(banks), .mode_o(mode), .outer_o(outer)
    );

    gfx_fetch_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .latch_en(latch_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .sel_o(sel)
    );

    gfx_page_compose #(.NUM_BANKS(NUM_BANKS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_comp (
        .clk(clk), .rst_n(rst_n), .bank_i(banks), .mode_i(mode), .outer_i(outer),
        .sel_i(sel), .latch_en(latch_en), .fetch_addr(fetch_addr), .page_o(page_o)
    );

    // R10: the cycle after reset the page sits in the default 8 KB block
    a_r10_reset_page: assert property (@(posedge clk)
        !rst_n |=> (page_o[PAGE_W-1:3] == PAGE_W'(8'h1F) >> 0 >> 0 ? page_o[PAGE_W-1:3] == (PAGE_W-3)'(5'h1F) : 1'b0) || rst_n);

endmodule

// File: tb/tb_gfx_bank_xlate.sv
module tb_gfx_bank_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        latch_en = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [13:0] fetch_addr = '0;
    logic [18:0] page_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] s_lo [8];
    logic [7:0] s_hi [8];
    logic [7:0] s_mode = '0;
    logic [7:0] s_outer = '0;
    logic [1:0] s_sel = '0;

    gfx_bank_xlate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .latch_en(latch_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .page_o(page_o)
    );

    always #4 clk = ~clk;

    function automatic logic [18:0] model(input logic [13:0] a);
        int g, idx, sh, raw, bank, lowbits, pg;
        g = int'(s_mode[4:3]);
        case (g)
            0: idx = 0;
            1: idx = 4 * int'(a[12]) + ((latch_en && s_sel[a[12]]) ? 2 : 0);
            2: idx = 4 * int'(a[12]) + 2 * int'(a[11]);
            default: idx = int'(a[12:10]);
        endcase
        raw = 256 * int'(s_hi[idx]) + int'(s_lo[idx]);
        sh  = 5 + g;
        if (s_outer[5]) bank = raw;
        else bank = (raw % (1 << sh)) + int'({s_outer[4:3], s_outer[0]}) * (1 << sh);
        lowbits = 1 << (3 - g);
        pg = bank * lowbits + (int'(a[12:10]) % lowbits);
        return 19'(pg);
    endfunction

    task automatic compare(input logic [18:0] exp, input string tag);
        n_checks++;
        if (page_o !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%h page actual=%h expected=%h", tag, fetch_addr, page_o, exp);
        end
    endtask

    task automatic chk(input logic [13:0] a, input string tag);
        @(negedge clk);
        fetch_addr  = a;
        fetch_valid = 1'b0;
        #1;
        compare(model(a), tag);
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (k)
            2'd0: s_lo[i] = d;
            2'd1: s_hi[i] = d;
            2'd2: s_mode  = d;
            default: s_outer = d;
        endcase
    endtask

    // valid fetch: checked against the old latch choice, then model updated
    task automatic trig(input logic [13:0] a, input string tag);
        @(negedge clk);
        fetch_addr  = a;
        fetch_valid = 1'b1;
        #1;
        compare(model(a), tag);
        @(posedge clk);
        #1;
        fetch_valid = 1'b0;
        if (!latch_en) s_sel = '0;
        else if (!a[13] && a[11:8] == 4'hF) begin
            if (a[7:4] == 4'hD) s_sel[a[12]] = 1'b0;
            else if (a[7:4] == 4'hE) s_sel[a[12]] = 1'b1;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] outers [5];
        outers = '{8'h00, 8'h19, 8'h07, 8'h20, 8'h3F};
        for (int i = 0; i < 8; i++) begin s_lo[i] = 8'hFF; s_hi[i] = 8'hFF; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, literal and modelled
        for (int s = 0; s < 8; s++) begin
            chk(14'(s << 10), "R10");
            n_checks++;
            if (page_o !== 19'(8'hF8 + s)) begin
                n_errors++;
                $display("FAIL R10 literal actual=%h expected=%h", page_o, 19'(8'hF8 + s));
            end
        end

        // load distinct bank contents (R1)
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 3'(i), 8'(8'h31 + 8'h1D * i));
            wr(2'd1, 3'(i), 8'(8'h80 ^ (8'h13 * i)));
        end

        // sweep granularity x outer control x slot
        foreach (outers[o]) begin
            wr(2'd3, 3'd0, outers[o]);
            for (int g = 0; g < 4; g++) begin
                wr(2'd2, 3'd0, 8'(g << 3));
                for (int s = 0; s < 8; s++) begin
                    string tag;
                    case (g)
                        0: tag = "R2";
                        1: tag = "R3";
                        2: tag = "R4";
                        default: tag = "R5";
                    endcase
                    tag = {tag, outers[o][5] ? "/R7" : "/R6"};
                    chk(14'((s << 10) | 14'h123), tag);
                end
            end
        end

        // R1: single-byte writes touch only their own byte
        wr(2'd3, 3'd0, 8'h20);
        wr(2'd2, 3'd0, 8'h18);
        wr(2'd0, 3'd5, 8'hA7);
        chk(14'h1400, "R1");
        wr(2'd1, 3'd3, 8'h5C);
        chk(14'h0C00, "R1");
        chk(14'h1400, "R1");
        chk(14'h0800, "R1");

        // latches in 4 KB mode, outer bypass
        wr(2'd2, 3'd0, 8'h08);
        @(negedge clk);
        latch_en = 1'b1;
        chk(14'h0000, "R8");
        trig(14'h0FE0, "R8");        // old choice shown on trigger
        chk(14'h0400, "R8");         // lower half now bank 2
        chk(14'h1400, "R8");         // upper half still bank 4
        trig(14'h1FE5, "R8");
        chk(14'h1C00, "R8");         // upper now bank 6
        trig(14'h1FD0, "R8");
        chk(14'h1000, "R8");         // upper back to bank 4
        trig(14'h2FD0, "R9");        // outside pattern space: ignored
        chk(14'h0000, "R9");
        trig(14'h0ED0, "R9");        // wrong row: ignored
        chk(14'h0000, "R9");
        @(negedge clk);
        fetch_addr = 14'h0FD0; fetch_valid = 1'b0;
        @(posedge clk);              // marker without valid: ignored
        chk(14'h0000, "R9");
        trig(14'h0FD3, "R8");
        chk(14'h0000, "R8");         // lower back to bank 0
        trig(14'h1FE0, "R8");        // upper to bank 6

        // strap low: banks 0/4, latches cleared
        @(negedge clk);
        latch_en = 1'b0;
        s_sel = '0;
        chk(14'h1000, "R9");
        chk(14'h1800, "R9");
        trig(14'h0FE0, "R9");
        chk(14'h0000, "R9");
        @(negedge clk);
        latch_en = 1'b1;
        chk(14'h1000, "R9");         // latch was cleared while strap low
        chk(14'h0000, "R9");

        finish_run();
    end

endmodule